// File: doc/BRIEF.md
# Single-Channel Cycle-Stealing DMA Engine

This block moves a block of words between one I/O device and memory without the processor copying each word itself. The processor sets it up through a small register port. It writes a device number, a starting memory address and a word count, then issues a start. The transfer direction comes from a separate control line that is sampled together with the start.

Once armed, the engine waits until the device is ready for one word. It then asks for the shared bus and holds the request until a grant arrives. The granted cycle is the single bus cycle that moves the word. The request drops right after that cycle, so the processor is held off for one bus cycle per word and never loses its context. After each word the address steps up by one and the count steps down by one. When the count is exhausted the engine raises a sticky completion flag, and the same flag drives an interrupt line. A later register write clears both.

Top module: `dma_steal_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_req, mem_we, mem_re, dev_ack, done and irq are all 0.
- R2: A write with cfg_we=1 selects a register with cfg_sel: 0 is the device number (shown on dev_sel), 1 is the memory address, 2 is the word count and 3 is control. In a control write, bit 0 of cfg_wdata is start and bit 1 is clear. The start write latches cfg_dir: 0 means device-to-memory and 1 means memory-to-device.
- R3: bus_req rises only in the cycle after the armed engine has seen dev_rdy=1 with a nonzero remaining count.
- R4: Each grant moves exactly one word. The memory strobe and dev_ack are high only in a cycle where both bus_req and bus_gnt are high, and bus_req is low in the next cycle.
- R5: In device-to-memory mode the granted cycle drives mem_we=1, mem_wdata=dev_rdata and dev_ack=1, with mem_re=0.
- R6: In memory-to-device mode the granted cycle drives mem_re=1, dev_wdata=mem_rdata and dev_ack=1, with mem_we=0.
- R7: After each moved word, mem_addr increases by one, wrapping modulo 2^AW, and the remaining count decreases by one.
- R8: Once the last word has moved, done rises two clock edges after the granted cycle, and no further bus_req occurs.
- R9: A start with a programmed count of zero sets done on the second edge after the start write, with no bus_req at all.
- R10: While a transfer is in progress, start, device, address and count writes have no effect.
- R11: done is sticky and irq mirrors it. Either a control write with the clear bit, or an accepted start, returns both to 0. If completion and a clear land on the same edge, completion wins.
- R12: While bus_req waits for a grant, mem_addr is stable and no memory strobe or dev_ack is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe from the processor |
| cfg_sel | input | 2 | Register select: 0 device, 1 memory address, 2 count, 3 control |
| cfg_dir | input | 1 | Direction line, sampled on an accepted start |
| cfg_wdata | input | DW | Register write data |
| bus_req | output | 1 | Bus request to the processor side |
| bus_gnt | input | 1 | Bus grant |
| mem_addr | output | AW | Current memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the strobe cycle |
| dev_sel | output | DEVW | Latched device number |
| dev_rdy | input | 1 | Device holds a word or can accept one |
| dev_rdata | input | DW | Word offered by the device |
| dev_wdata | output | DW | Word delivered to the device |
| dev_ack | output | 1 | One word taken from or given to the device |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt line following done |

## Verification
The bench builds the engine with an 8-bit data path, a 4-bit memory address, a 3-bit device field and a 5-bit count. With a 4-bit address, a block that starts at address 14 wraps to address 0 partway through, so the wrap case of R7 is exercised. The small memory also lets every word be preloaded and checked at the end. The bench varies the grant latency and how often the device is ready. This covers back-to-back words, long waits for a grant and long waits for the device.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_REQ   = 2'd2
    } phase_e;

    typedef enum logic {
        DIR_DEV2MEM = 1'b0,
        DIR_MEM2DEV = 1'b1
    } dir_e;

    localparam logic [1:0] SEL_DEVICE  = 2'd0;
    localparam logic [1:0] SEL_MEMADDR = 2'd1;
    localparam logic [1:0] SEL_COUNT   = 2'd2;
    localparam logic [1:0] SEL_CTRL    = 2'd3;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_CLEAR_BIT = 1;

    typedef struct packed {
        logic start;
        logic clear;
    } ctrl_cmd_t;

    typedef struct packed {
        logic step;
        logic finish;
        logic busy;
    } seq_evt_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic we, input logic [1:0] sel,
                                              input logic [1:0] low_bits);
        ctrl_cmd_t c;
        c.start = we && (sel == SEL_CTRL) && low_bits[CTRL_START_BIT];
        c.clear = we && (sel == SEL_CTRL) && low_bits[CTRL_CLEAR_BIT];
        return c;
    endfunction

    function automatic phase_e phase_next(input phase_e cur, input logic start_ok,
                                          input logic cnt_zero, input logic rdy,
                                          input logic gnt);
        phase_e n;
        n = cur;
        unique case (cur)
            PH_IDLE:  if (start_ok) n = PH_ARMED;
            PH_ARMED: if (cnt_zero) n = PH_IDLE;
                      else if (rdy) n = PH_REQ;
            PH_REQ:   if (gnt) n = PH_ARMED;
            default:  n = PH_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dma_cfg_file.sv
module dma_cfg_file
    import dma_steal_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 32,
    parameter int DEVW = 8,
    parameter int CW   = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic            cfg_dir,
    input  logic [DW-1:0]   cfg_wdata,
    input  seq_evt_t        evt,
    output logic            start_ok,
    output logic            cnt_zero,
    output dir_e            dir,
    output logic [DEVW-1:0] dev_num,
    output logic [AW-1:0]   addr,
    output logic            done
);
    localparam logic [AW-1:0] ADDR_ONE = AW'(1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    ctrl_cmd_t       cmd;
    logic            idle_wr;
    logic [CW-1:0]   count_q;

    assign cmd      = decode_ctrl(cfg_we, cfg_sel, cfg_wdata[1:0]);
    assign idle_wr  = cfg_we && !evt.busy;
    assign start_ok = cmd.start && !evt.busy;
    assign cnt_zero = (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_num <= '0;
            addr    <= '0;
            count_q <= '0;
            dir     <= DIR_DEV2MEM;
        end else if (evt.step) begin
            addr    <= addr + ADDR_ONE;
            count_q <= count_q - CNT_ONE;
        end else if (idle_wr) begin
            unique case (cfg_sel)
                SEL_DEVICE:  dev_num <= DEVW'(cfg_wdata);
                SEL_MEMADDR: addr    <= AW'(cfg_wdata);
                SEL_COUNT:   count_q <= CW'(cfg_wdata);
                default: begin
                    if (start_ok) dir <= dir_e'(cfg_dir);
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                done <= 1'b0;
        else if (evt.finish)                    done <= 1'b1;
        else if (cmd.clear || start_ok)         done <= 1'b0;
    end

endmodule

// File: rtl/dma_phase_fsm.sv
module dma_phase_fsm
    import dma_steal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_ok,
    input  logic     cnt_zero,
    input  logic     dev_rdy,
    input  logic     bus_gnt,
    output phase_e   phase,
    output seq_evt_t evt
);
    phase_e phase_d;

    assign phase_d    = phase_next(phase, start_ok, cnt_zero, dev_rdy, bus_gnt);
    assign evt.step   = (phase == PH_REQ) && bus_gnt;
    assign evt.finish = (phase == PH_ARMED) && cnt_zero;
    assign evt.busy   = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_d;
    end

endmodule

// File: rtl/dma_xfer_route.sv
module dma_xfer_route
    import dma_steal_pkg::*;
#(
    parameter int DW = 32
) (
    input  phase_e        phase,
    input  logic          bus_gnt,
    input  dir_e          dir,
    input  logic [DW-1:0] dev_rdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          bus_req,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] dev_wdata,
    output logic          dev_ack
);
    logic owned;

    always_comb begin
        bus_req   = (phase == PH_REQ);
        owned     = bus_req && bus_gnt;
        mem_we    = owned && (dir == DIR_DEV2MEM);
        mem_re    = owned && (dir == DIR_MEM2DEV);
        dev_ack   = owned;
        mem_wdata = mem_we ? dev_rdata : '0;
        dev_wdata = mem_re ? mem_rdata : '0;
    end

endmodule

// File: rtl/dma_steal_engine.sv
module dma_steal_engine
    import dma_steal_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 32,
    parameter int DEVW = 8,
    parameter int CW   = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic            cfg_dir,
    input  logic [DW-1:0]   cfg_wdata,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we,
    output logic            mem_re,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DEVW-1:0] dev_sel,
    input  logic            dev_rdy,
    input  logic [DW-1:0]   dev_rdata,
    output logic [DW-1:0]   dev_wdata,
    output logic            dev_ack,
    output logic            done,
    output logic            irq
);
    phase_e   phase;
    seq_evt_t evt;
    logic     start_ok;
    logic     cnt_zero;
    dir_e     dir;

    dma_cfg_file #(.DW(DW), .AW(AW), .DEVW(DEVW), .CW(CW)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_dir  (cfg_dir),
        .cfg_wdata(cfg_wdata),
        .evt      (evt),
        .start_ok (start_ok),
        .cnt_zero (cnt_zero),
        .dir      (dir),
        .dev_num  (dev_sel),
        .addr     (mem_addr),
        .done     (done)
    );

    dma_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start_ok(start_ok),
        .cnt_zero(cnt_zero),
        .dev_rdy (dev_rdy),
        .bus_gnt (bus_gnt),
        .phase   (phase),
        .evt     (evt)
    );

    dma_xfer_route #(.DW(DW)) u_route (
        .phase    (phase),
        .bus_gnt  (bus_gnt),
        .dir      (dir),
        .dev_rdata(dev_rdata),
        .mem_rdata(mem_rdata),
        .bus_req  (bus_req),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .mem_wdata(mem_wdata),
        .dev_wdata(dev_wdata),
        .dev_ack  (dev_ack)
    );

    assign irq = done;

endmodule

// File: rtl/dma_steal_checker.sv
module dma_steal_checker #(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_we,
    input logic [1:0]    cfg_sel,
    input logic [DW-1:0] cfg_wdata,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re,
    input logic          dev_rdy,
    input logic          dev_ack,
    input logic          done
);
    logic ctrl_release;
    assign ctrl_release = cfg_we && (cfg_sel == 2'd3) && (cfg_wdata[0] || cfg_wdata[1]);

    AST_REQ_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(dev_rdy)); // R3
    AST_SINGLE_WORD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt) |=> !bus_req); // R4
    AST_STROBE_IN_GRANT: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re || dev_ack) |-> (bus_req && bus_gnt)); // R4
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)); // R5
    AST_ACK_PAIRED: assert property (@(posedge clk) disable iff (rst)
        dev_ack |-> (mem_we || mem_re)); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_gnt) |=> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R7
    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_req); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && !ctrl_release) |=> done); // R11
    AST_WAIT_HOLDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> $stable(mem_addr)); // R12

endmodule

bind dma_steal_engine dma_steal_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .dev_rdy  (dev_rdy),
    .dev_ack  (dev_ack),
    .done     (done)
);

// File: tb/dma_steal_engine_test.sv
`timescale 1ns/1ps
module dma_steal_engine_test;
    localparam int DW = 8, AW = 4, DEVW = 3, CW = 5;
    localparam int MEMN = 1 << AW;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic cfg_dir = 1'b0;
    logic [DW-1:0] cfg_wdata = '0;
    logic bus_req, bus_gnt;
    logic [AW-1:0] mem_addr;
    logic mem_we, mem_re;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [DEVW-1:0] dev_sel;
    logic dev_rdy;
    logic [DW-1:0] dev_rdata, dev_wdata;
    logic dev_ack, done, irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [DW-1:0] mem [MEMN];
    int src_base = 0, src_idx = 0;
    logic [DW-1:0] sink [$];
    int gnt_lat = 0, rdy_mode = 0, wcnt = 0;

    // reference model state
    int m_ph = 0, m_done = 0, m_dev = 0, m_addr = 0, m_cnt = 0, m_dir = 0;

    always #2.5 clk = ~clk;

    dma_steal_engine #(.DW(DW), .AW(AW), .DEVW(DEVW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_dir(cfg_dir),
        .cfg_wdata(cfg_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_sel(dev_sel), .dev_rdy(dev_rdy), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
        .dev_ack(dev_ack), .done(done), .irq(irq)
    );

    assign mem_rdata = mem[mem_addr];
    assign dev_rdata = DW'(src_base + src_idx);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // bus arbiter and device readiness, driven away from the active edge
    initial begin
        bus_gnt = 1'b0;
        dev_rdy = 1'b0;
        forever begin
            @(negedge clk);
            if (!bus_req) begin
                wcnt = 0;
                bus_gnt = 1'b0;
            end else begin
                if (wcnt >= gnt_lat) bus_gnt = 1'b1;
                wcnt++;
            end
            case (rdy_mode)
                0: dev_rdy = 1'b1;
                1: dev_rdy = ~dev_rdy;
                default: dev_rdy = 1'b0;
            endcase
        end
    end

    // memory and device behaviour, plus the reference model
    always @(posedge clk) begin
        int clr, strt;
        cycles++;
        if (!rst && mem_we) mem[mem_addr] = mem_wdata;
        if (!rst && dev_ack && mem_we) src_idx++;
        if (!rst && dev_ack && mem_re) sink.push_back(dev_wdata);
        if (rst) begin
            m_ph = 0; m_done = 0; m_dev = 0; m_addr = 0; m_cnt = 0; m_dir = 0;
        end else begin
            clr = 0; strt = 0;
            if (cfg_we && cfg_sel == 2'd3) begin
                strt = int'(cfg_wdata[0]);
                clr  = int'(cfg_wdata[0] | cfg_wdata[1]);
            end
            case (m_ph)
                0: begin
                    if (clr != 0) m_done = 0;
                    if (cfg_we && cfg_sel == 2'd0) m_dev = int'(cfg_wdata) % (1 << DEVW);
                    if (cfg_we && cfg_sel == 2'd1) m_addr = int'(cfg_wdata) % MEMN;
                    if (cfg_we && cfg_sel == 2'd2) m_cnt = int'(cfg_wdata) % (1 << CW);
                    if (strt != 0) begin m_ph = 1; m_dir = int'(cfg_dir); end
                end
                1: begin
                    if (cfg_we && cfg_sel == 2'd3 && cfg_wdata[1]) m_done = 0;
                    if (m_cnt == 0) begin m_done = 1; m_ph = 0; end
                    else if (dev_rdy) m_ph = 2;
                end
                default: begin
                    if (cfg_we && cfg_sel == 2'd3 && cfg_wdata[1]) m_done = 0;
                    if (bus_gnt) begin
                        m_addr = (m_addr + 1) % MEMN;
                        m_cnt  = m_cnt - 1;
                        m_ph   = 1;
                    end
                end
            endcase
        end
    end

    // per-cycle comparison, 1 ns after the edge
    always @(posedge clk) begin
        int xfer;
        #1;
        xfer = (m_ph == 2 && bus_gnt) ? 1 : 0;
        chk("R3", "bus_req", int'(bus_req), (m_ph == 2) ? 1 : 0);
        chk("R11", "done", int'(done), m_done);
        chk("R11", "irq", int'(irq), m_done);
        chk("R7", "mem_addr", int'(mem_addr), m_addr);
        chk("R2", "dev_sel", int'(dev_sel), m_dev);
        chk("R5", "mem_we", int'(mem_we), (xfer == 1 && m_dir == 0) ? 1 : 0);
        chk("R6", "mem_re", int'(mem_re), (xfer == 1 && m_dir == 1) ? 1 : 0);
        chk("R4", "dev_ack", int'(dev_ack), xfer);
        if (xfer == 1 && m_dir == 0) chk("R5", "mem_wdata", int'(mem_wdata), int'(dev_rdata));
        if (xfer == 1 && m_dir == 1) chk("R6", "dev_wdata", int'(dev_wdata), int'(mem[m_addr]));
    end

    always @(posedge clk) begin
        if (cycles > WATCHDOG) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input int data, input logic dir);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = DW'(data); cfg_dir = dir;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < MEMN; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1", "bus_req in reset", int'(bus_req), 0);
        chk("R1", "done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "irq after reset", int'(irq), 0);
        chk("R1", "mem_we after reset", int'(mem_we | mem_re | dev_ack), 0);

        // device-to-memory, immediate grant, device always ready
        src_base = 8'h30; src_idx = 0; rdy_mode = 0; gnt_lat = 0;
        cfg_write(2'd0, 5, 1'b0);
        cfg_write(2'd1, 2, 1'b0);
        cfg_write(2'd2, 3, 1'b0);
        cfg_write(2'd3, 1, 1'b0);
        wait_done();
        chk("R2", "dev_sel", int'(dev_sel), 5);
        chk("R5", "mem[2]", int'(mem[2]), 8'h30);
        chk("R5", "mem[3]", int'(mem[3]), 8'h31);
        chk("R5", "mem[4]", int'(mem[4]), 8'h32);
        chk("R7", "end address", int'(mem_addr), 5);
        chk("R8", "words moved", src_idx, 3);

        // memory-to-device with wrap, slow grant, toggling readiness
        for (int i = 0; i < MEMN; i++) mem[i] = DW'(8'hA0 + i);
        sink.delete();
        rdy_mode = 1; gnt_lat = 2;
        cfg_write(2'd1, 14, 1'b0);
        cfg_write(2'd2, 4, 1'b0);
        cfg_write(2'd3, 1, 1'b1);
        @(negedge clk);
        chk("R11", "done cleared by start", int'(done), 0);
        wait_done();
        chk("R6", "sink size", sink.size(), 4);
        if (sink.size() == 4) begin
            chk("R6", "word0", int'(sink[0]), 8'hAE);
            chk("R6", "word1", int'(sink[1]), 8'hAF);
            chk("R7", "wrapped word2", int'(sink[2]), 8'hA0);
            chk("R7", "wrapped word3", int'(sink[3]), 8'hA1);
        end
        chk("R7", "wrapped address", int'(mem_addr), 2);

        // done stays set while idle, then a clear write drops it
        repeat (5) @(negedge clk);
        chk("R11", "done sticky", int'(done), 1);
        cfg_write(2'd3, 2, 1'b0);
        chk("R11", "done after clear", int'(done), 0);
        chk("R11", "irq after clear", int'(irq), 0);

        // zero count completes without a bus request
        cfg_write(2'd2, 0, 1'b0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 8'd1; cfg_dir = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
        chk("R9", "done one edge after start", int'(done), 0);
        @(negedge clk);
        chk("R9", "done two edges after start", int'(done), 1);
        chk("R9", "no bus_req", int'(bus_req), 0);

        // writes and start while busy are ignored
        for (int i = 0; i < MEMN; i++) mem[i] = '0;
        src_base = 8'h50; src_idx = 0; rdy_mode = 2; gnt_lat = 1;
        cfg_write(2'd1, 8, 1'b0);
        cfg_write(2'd2, 2, 1'b0);
        cfg_write(2'd3, 1, 1'b0);
        cfg_write(2'd2, 9, 1'b0);
        cfg_write(2'd1, 0, 1'b0);
        cfg_write(2'd0, 2, 1'b1);
        cfg_write(2'd3, 1, 1'b1);
        chk("R10", "address unchanged while busy", int'(mem_addr), 8);
        chk("R10", "device unchanged while busy", int'(dev_sel), 5);
        chk("R12", "no request without ready", int'(bus_req), 0);
        rdy_mode = 0;
        wait_done();
        chk("R10", "words moved", src_idx, 2);
        chk("R10", "mem[8]", int'(mem[8]), 8'h50);
        chk("R10", "mem[9]", int'(mem[9]), 8'h51);
        chk("R10", "mem[0] untouched", int'(mem[0]), 0);
        chk("R7", "final address", int'(mem_addr), 10);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule